// File: doc/BRIEF.md
# Boundary-Scan Instruction Decoder with Signal-Integrity Test Modes

This block is the control core of a boundary-scan test access port. It holds the 16-state test controller, which advances on TCK under TMS. It also holds a 4-bit instruction register and a one-bit bypass register. Around them sits the decode logic that tells the boundary cells what to do. Besides the usual bypass, preload/sample and external-test instructions, it decodes two instructions for interconnect signal-integrity testing.

The first, the pattern-generate instruction, puts the pattern-generating cells into integrity mode and arms the loss sensors at the receiving cells. While it is active, Shift-DR loads victim-select data into the boundary chain, and every Update-DR steps the pattern. The second, the observe instruction, keeps integrity mode selected but disarms the sensors, so the stored loss flags can be captured and scanned out.

A typical test preloads a seed, runs pattern generation, and then reads the flags with the observe instruction. Cores that are not under test stay in bypass. The block only drives the strobes and mode lines; the cells themselves are outside it.

Top module: `sitap_top`

## Requirements
- R1: The controller follows the standard 16-state TMS graph, and `tap_state` shows the state in this encoding: Exit2-DR 0, Exit1-DR 1, Shift-DR 2, Pause-DR 3, Select-IR 4, Update-DR 5, Capture-DR 6, Select-DR 7, Exit2-IR 8, Exit1-IR 9, Shift-IR A, Pause-IR B, Run-Idle C, Update-IR D, Capture-IR E, Test-Logic-Reset F.
- R2: The active instruction `cur_instr` changes only on the clock edge taken in Update-IR, where it takes the shifted value. In Capture-IR the shift stage loads 4'b0001. During Shift-IR, TDI enters at the MSB and TDO shows the LSB.
- R3: Opcode 4'h8 (pattern generate) sets `integ_sel`=1 and `sense_en`=1 and selects the boundary register.
- R4: Under opcode 4'h8, `bsr_capture`, `bsr_shift` and `bsr_update` are high in Capture-DR, Shift-DR and Update-DR respectively. Each DR scan gives exactly one `bsr_update` pulse, which steps the pattern once.
- R5: Opcode 4'h9 (observe) sets `integ_sel`=1 and `sense_en`=0 and selects the boundary register, so the sensor flags are captured and shifted out.
- R6: Opcodes 4'h2 (preload/sample) and 4'h0 (external test) select the boundary register with both integrity lines at 0. Only 4'h0 raises `ext_drive`.
- R7: Opcode 4'hF, and every opcode not named above, selects the bypass register. That register loads 0 in Capture-DR and delays TDI by one shift. No boundary strobe fires.
- R8: Entering Test-Logic-Reset, or a high `rst` at a clock edge, sets the instruction to 4'hF and all mode lines to 0. `rst` wins over an Update-IR edge in the same cycle.
- R9: TDO and `tdo_en` change on the falling edge of TCK. `tdo_en` is 1 only in Shift-IR and Shift-DR, and TDO is 0 whenever `tdo_en` is 0. In Shift-DR, TDO follows `bsr_tdo` when the boundary register is selected.
- R10: At most one boundary strobe is high at a time, and each is high only in its own controller state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high reset |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial test data in |
| bsr_tdo | input | 1 | Serial output of the boundary register |
| tdo | output | 1 | Serial test data out, falling-edge timed |
| tdo_en | output | 1 | TDO driver enable |
| tap_state | output | 4 | Current controller state (R1 encoding) |
| cur_instr | output | 4 | Active instruction |
| integ_sel | output | 1 | Integrity-mode select to the enhanced cells |
| sense_en | output | 1 | Loss-sensor capture enable |
| ext_drive | output | 1 | Boundary cells drive the pins |
| bsr_capture | output | 1 | Boundary register capture strobe |
| bsr_shift | output | 1 | Boundary register shift strobe |
| bsr_update | output | 1 | Boundary register update strobe |

## Verification
The instruction latch on the Update-IR edge and the synchronous reset can fall on the same edge. The bench provokes this by shifting in the generate opcode, stopping in Update-IR and raising `rst` for that one edge. It then judges the result: the instruction must come out as bypass, the controller must be in Test-Logic-Reset and both integrity lines must stay low, rather than taking the shifted opcode. Random opcode loads, each followed by a DR scan of random length, check strobe routing and TDO selection against a bench decode table. A random TMS walk is compared state by state with a bench model of the controller graph.

// File: rtl/sitap_pkg.sv
package sitap_pkg;

  typedef enum logic [3:0] {
    ST_X2DR = 4'h0,
    ST_X1DR = 4'h1,
    ST_SHDR = 4'h2,
    ST_PSDR = 4'h3,
    ST_SLIR = 4'h4,
    ST_UPDR = 4'h5,
    ST_CPDR = 4'h6,
    ST_SLDR = 4'h7,
    ST_X2IR = 4'h8,
    ST_X1IR = 4'h9,
    ST_SHIR = 4'hA,
    ST_PSIR = 4'hB,
    ST_IDLE = 4'hC,
    ST_UPIR = 4'hD,
    ST_CPIR = 4'hE,
    ST_TLR  = 4'hF
  } tap_st_t;

  typedef struct packed {
    logic integ_sel;
    logic sense_en;
    logic ext_drive;
    logic bsr_sel;
  } ictl_t;

endpackage

// File: rtl/sitap_fsm.sv
module sitap_fsm
  import sitap_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    tms,
  output tap_st_t st
);

  tap_st_t nxt;

  always_comb begin
    unique case (st)
      ST_TLR:  nxt = tms ? ST_TLR  : ST_IDLE;
      ST_IDLE: nxt = tms ? ST_SLDR : ST_IDLE;
      ST_SLDR: nxt = tms ? ST_SLIR : ST_CPDR;
      ST_CPDR: nxt = tms ? ST_X1DR : ST_SHDR;
      ST_SHDR: nxt = tms ? ST_X1DR : ST_SHDR;
      ST_X1DR: nxt = tms ? ST_UPDR : ST_PSDR;
      ST_PSDR: nxt = tms ? ST_X2DR : ST_PSDR;
      ST_X2DR: nxt = tms ? ST_UPDR : ST_SHDR;
      ST_UPDR: nxt = tms ? ST_SLDR : ST_IDLE;
      ST_SLIR: nxt = tms ? ST_TLR  : ST_CPIR;
      ST_CPIR: nxt = tms ? ST_X1IR : ST_SHIR;
      ST_SHIR: nxt = tms ? ST_X1IR : ST_SHIR;
      ST_X1IR: nxt = tms ? ST_UPIR : ST_PSIR;
      ST_PSIR: nxt = tms ? ST_X2IR : ST_PSIR;
      ST_X2IR: nxt = tms ? ST_UPIR : ST_SHIR;
      ST_UPIR: nxt = tms ? ST_SLDR : ST_IDLE;
      default: nxt = ST_TLR;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st <= ST_TLR;
    else     st <= nxt;
  end

endmodule

// File: rtl/sitap_ir.sv
module sitap_ir
  import sitap_pkg::*;
#(
  parameter int              IR_W       = 4,
  parameter logic [IR_W-1:0] OP_BYPASS  = '1,
  parameter logic [IR_W-1:0] OP_EXTEST  = 4'h0,
  parameter logic [IR_W-1:0] OP_PRELOAD = 4'h2,
  parameter logic [IR_W-1:0] OP_GEN     = 4'h8,
  parameter logic [IR_W-1:0] OP_OBS     = 4'h9
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tdi,
  input  tap_st_t         st,
  output logic [IR_W-1:0] instr,
  output ictl_t           ctl,
  output logic            ir_lsb
);

  localparam logic [IR_W-1:0] CAP_PAT = {{(IR_W-1){1'b0}}, 1'b1};

  logic [IR_W-1:0] shreg;
  ictl_t           dec;

  always_ff @(posedge clk) begin
    if (rst)                  shreg <= CAP_PAT;
    else if (st == ST_CPIR)   shreg <= CAP_PAT;
    else if (st == ST_SHIR)   shreg <= {tdi, shreg[IR_W-1:1]};
  end

  always_comb begin
    dec = '0;
    if (shreg == OP_GEN) begin
      dec.integ_sel = 1'b1;
      dec.sense_en  = 1'b1;
      dec.bsr_sel   = 1'b1;
    end else if (shreg == OP_OBS) begin
      dec.integ_sel = 1'b1;
      dec.bsr_sel   = 1'b1;
    end else if (shreg == OP_EXTEST) begin
      dec.ext_drive = 1'b1;
      dec.bsr_sel   = 1'b1;
    end else if (shreg == OP_PRELOAD) begin
      dec.bsr_sel   = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || st == ST_TLR) begin
      instr <= OP_BYPASS;
      ctl   <= '0;
    end else if (st == ST_UPIR) begin
      instr <= shreg;
      ctl   <= dec;
    end
  end

  assign ir_lsb = shreg[0];

endmodule

// File: rtl/sitap_dr.sv
module sitap_dr
  import sitap_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    tdi,
  input  tap_st_t st,
  input  logic    bsr_sel,
  input  logic    ir_lsb,
  input  logic    bsr_tdo,
  output logic    bsr_capture,
  output logic    bsr_shift,
  output logic    bsr_update,
  output logic    tdo,
  output logic    tdo_en
);

  logic byp;

  always_ff @(posedge clk) begin
    if (rst)                 byp <= 1'b0;
    else if (st == ST_CPDR)  byp <= 1'b0;
    else if (st == ST_SHDR)  byp <= tdi;
  end

  assign bsr_capture = bsr_sel && (st == ST_CPDR);
  assign bsr_shift   = bsr_sel && (st == ST_SHDR);
  assign bsr_update  = bsr_sel && (st == ST_UPDR);

  always_ff @(negedge clk) begin
    if (rst) begin
      tdo    <= 1'b0;
      tdo_en <= 1'b0;
    end else if (st == ST_SHIR) begin
      tdo    <= ir_lsb;
      tdo_en <= 1'b1;
    end else if (st == ST_SHDR) begin
      tdo    <= bsr_sel ? bsr_tdo : byp;
      tdo_en <= 1'b1;
    end else begin
      tdo    <= 1'b0;
      tdo_en <= 1'b0;
    end
  end

endmodule

// File: rtl/sitap_top.sv
module sitap_top
  import sitap_pkg::*;
#(
  parameter int              IR_W       = 4,
  parameter logic [IR_W-1:0] OP_BYPASS  = '1,
  parameter logic [IR_W-1:0] OP_EXTEST  = 4'h0,
  parameter logic [IR_W-1:0] OP_PRELOAD = 4'h2,
  parameter logic [IR_W-1:0] OP_GEN     = 4'h8,
  parameter logic [IR_W-1:0] OP_OBS     = 4'h9
) (
  input  logic            tck,
  input  logic            rst,
  input  logic            tms,
  input  logic            tdi,
  input  logic            bsr_tdo,
  output logic            tdo,
  output logic            tdo_en,
  output logic [3:0]      tap_state,
  output logic [IR_W-1:0] cur_instr,
  output logic            integ_sel,
  output logic            sense_en,
  output logic            ext_drive,
  output logic            bsr_capture,
  output logic            bsr_shift,
  output logic            bsr_update
);

  tap_st_t st;
  ictl_t   ctl;
  logic    ir_lsb;

  sitap_fsm u_fsm (
    .clk (tck),
    .rst (rst),
    .tms (tms),
    .st  (st)
  );

  sitap_ir #(
    .IR_W       (IR_W),
    .OP_BYPASS  (OP_BYPASS),
    .OP_EXTEST  (OP_EXTEST),
    .OP_PRELOAD (OP_PRELOAD),
    .OP_GEN     (OP_GEN),
    .OP_OBS     (OP_OBS)
  ) u_ir (
    .clk    (tck),
    .rst    (rst),
    .tdi    (tdi),
    .st     (st),
    .instr  (cur_instr),
    .ctl    (ctl),
    .ir_lsb (ir_lsb)
  );

  sitap_dr u_dr (
    .clk         (tck),
    .rst         (rst),
    .tdi         (tdi),
    .st          (st),
    .bsr_sel     (ctl.bsr_sel),
    .ir_lsb      (ir_lsb),
    .bsr_tdo     (bsr_tdo),
    .bsr_capture (bsr_capture),
    .bsr_shift   (bsr_shift),
    .bsr_update  (bsr_update),
    .tdo         (tdo),
    .tdo_en      (tdo_en)
  );

  assign tap_state = st;
  assign integ_sel = ctl.integ_sel;
  assign sense_en  = ctl.sense_en;
  assign ext_drive = ctl.ext_drive;

endmodule

// File: rtl/sitap_chk.sv
module sitap_chk #(
  parameter int IR_W = 4
) (
  input logic            tck,
  input logic            rst,
  input logic            tms,
  input logic [3:0]      tap_state,
  input logic [IR_W-1:0] cur_instr,
  input logic            integ_sel,
  input logic            sense_en,
  input logic            ext_drive,
  input logic            bsr_capture,
  input logic            bsr_shift,
  input logic            bsr_update
);

  AST_TLR_HOLD: assert property (@(posedge tck) disable iff (rst)
    (tap_state == 4'hF && tms) |=> tap_state == 4'hF); // R1

  AST_IR_HOLD: assert property (@(posedge tck) disable iff (rst)
    (tap_state != 4'hD && tap_state != 4'hF) |=> $stable(cur_instr)); // R2

  AST_GEN_CTRL: assert property (@(posedge tck) disable iff (rst)
    cur_instr == 4'h8 |-> (integ_sel && sense_en)); // R3

  AST_OBS_CTRL: assert property (@(posedge tck) disable iff (rst)
    cur_instr == 4'h9 |-> (integ_sel && !sense_en)); // R5

  AST_BYP_QUIET: assert property (@(posedge tck) disable iff (rst)
    cur_instr == 4'hF |-> !(bsr_capture || bsr_shift || bsr_update)); // R7

  AST_RESET_BYPASS: assert property (@(posedge tck) disable iff (rst)
    tap_state == 4'hF |=> (cur_instr == 4'hF && !integ_sel && !sense_en && !ext_drive)); // R8

  AST_STROBE_EXCL: assert property (@(posedge tck) disable iff (rst)
    $onehot0({bsr_capture, bsr_shift, bsr_update})); // R10

  AST_UPDATE_STATE: assert property (@(posedge tck) disable iff (rst)
    bsr_update |-> tap_state == 4'h5); // R10

endmodule

bind sitap_top sitap_chk #(.IR_W(IR_W)) u_chk (
  .tck         (tck),
  .rst         (rst),
  .tms         (tms),
  .tap_state   (tap_state),
  .cur_instr   (cur_instr),
  .integ_sel   (integ_sel),
  .sense_en    (sense_en),
  .ext_drive   (ext_drive),
  .bsr_capture (bsr_capture),
  .bsr_shift   (bsr_shift),
  .bsr_update  (bsr_update)
);

// File: tb/test_sitap_top.sv
module test_sitap_top;

  logic       tck = 1'b0;
  logic       rst = 1'b1;
  logic       tms = 1'b1;
  logic       tdi = 1'b0;
  logic       bsr_tdo = 1'b0;
  logic       tdo, tdo_en, integ_sel, sense_en, ext_drive;
  logic       bsr_capture, bsr_shift, bsr_update;
  logic [3:0] tap_state, cur_instr;

  int n_run  = 0;
  int n_fail = 0;
  int upd_cnt;
  logic [3:0] model_st;

  always #4 tck = ~tck;

  sitap_top i_sitap_top (
    .tck(tck), .rst(rst), .tms(tms), .tdi(tdi), .bsr_tdo(bsr_tdo),
    .tdo(tdo), .tdo_en(tdo_en), .tap_state(tap_state), .cur_instr(cur_instr),
    .integ_sel(integ_sel), .sense_en(sense_en), .ext_drive(ext_drive),
    .bsr_capture(bsr_capture), .bsr_shift(bsr_shift), .bsr_update(bsr_update)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // bench decode table: {integ_sel, sense_en, ext_drive, bsr_sel}
  function automatic logic [3:0] exp_ctl(input logic [3:0] c);
    case (c)
      4'h8:    return 4'b1101;
      4'h9:    return 4'b1001;
      4'h0:    return 4'b0011;
      4'h2:    return 4'b0001;
      default: return 4'b0000;
    endcase
  endfunction

  function automatic logic [3:0] exp_next(input logic [3:0] s, input logic m);
    case (s)
      4'hF: return m ? 4'hF : 4'hC;
      4'hC: return m ? 4'h7 : 4'hC;
      4'h7: return m ? 4'h4 : 4'h6;
      4'h6: return m ? 4'h1 : 4'h2;
      4'h2: return m ? 4'h1 : 4'h2;
      4'h1: return m ? 4'h5 : 4'h3;
      4'h3: return m ? 4'h0 : 4'h3;
      4'h0: return m ? 4'h5 : 4'h2;
      4'h5: return m ? 4'h7 : 4'hC;
      4'h4: return m ? 4'hF : 4'hE;
      4'hE: return m ? 4'h9 : 4'hA;
      4'hA: return m ? 4'h9 : 4'hA;
      4'h9: return m ? 4'hD : 4'hB;
      4'hB: return m ? 4'h8 : 4'hB;
      4'h8: return m ? 4'hD : 4'hA;
      default: return m ? 4'h7 : 4'hC;
    endcase
  endfunction

  // inputs change 6 ns after a rising edge; outputs read there too,
  // after the falling edge has updated TDO
  task automatic step(input logic m, input logic d);
    tms = m;
    tdi = d;
    @(posedge tck);
    #6;
    if (bsr_update && cur_instr == 4'h8) upd_cnt++;
  endtask

  task automatic shift_ir_to_update(input logic [3:0] code);
    logic [3:0] got;
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < 4; i++) begin
      got[i] = tdo;
      step(i == 3, code[i]);
    end
    chk(got == 4'b0001, "R2", "IR capture pattern on TDO", got, 4'b0001);
    step(1, 0);
  endtask

  task automatic load_ir(input logic [3:0] code);
    logic [3:0] old;
    old = cur_instr;
    shift_ir_to_update(code);
    chk(cur_instr == old, "R2", "instr before update edge", cur_instr, old);
    step(0, 0);
    chk(cur_instr == code, "R2", "instr after update", cur_instr, code);
    chk({integ_sel, sense_en, ext_drive} == exp_ctl(code) >> 1, "R3",
        "mode lines after load", {integ_sel, sense_en, ext_drive}, exp_ctl(code) >> 1);
  endtask

  task automatic dr_scan(input int len);
    logic sel, expv, prev_b, d;
    sel = exp_ctl(cur_instr)[0];
    step(1, 0);
    step(0, 0);
    chk(bsr_capture == sel, "R4", "capture strobe", bsr_capture, sel);
    prev_b = 1'($urandom);
    bsr_tdo = prev_b;
    step(0, 0);
    chk(bsr_shift == sel, "R4", "shift strobe", bsr_shift, sel);
    expv = sel ? prev_b : 1'b0;
    for (int i = 0; i < len; i++) begin
      chk(tdo_en == 1'b1, "R9", "tdo_en in Shift-DR", tdo_en, 1);
      chk(tdo == expv, sel ? "R9" : "R7", "DR TDO bit", tdo, expv);
      d = 1'($urandom);
      prev_b = 1'($urandom);
      bsr_tdo = prev_b;
      step(i == len - 1, d);
      expv = sel ? prev_b : d;
    end
    chk(tdo_en == 1'b0 && tdo == 1'b0, "R9", "TDO idle after shift", {tdo_en, tdo}, 0);
    step(1, 0);
    chk(bsr_update == sel, "R4", "update strobe", bsr_update, sel);
    chk(bsr_shift == 1'b0 && bsr_capture == 1'b0, "R10", "single strobe",
        {bsr_capture, bsr_shift}, 0);
    step(0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge tck);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4517));
    upd_cnt = 0;
    repeat (3) @(posedge tck);
    #6;
    rst = 1'b0;
    chk(tap_state == 4'hF, "R8", "state after reset", tap_state, 4'hF);
    chk(cur_instr == 4'hF, "R8", "instr after reset", cur_instr, 4'hF);
    chk({integ_sel, sense_en, ext_drive} == 3'b000, "R8", "mode after reset",
        {integ_sel, sense_en, ext_drive}, 0);
    chk(tdo_en == 1'b0, "R9", "tdo_en after reset", tdo_en, 0);
    step(0, 0);
    chk(tap_state == 4'hC, "R1", "enter Run-Idle", tap_state, 4'hC);

    // bypass path
    dr_scan(8);

    // preload seed, generate, observe
    load_ir(4'h2);
    chk(ext_drive == 1'b0, "R6", "preload no drive", ext_drive, 0);
    dr_scan(6);
    load_ir(4'h8);
    chk(integ_sel && sense_en, "R3", "generate lines", {integ_sel, sense_en}, 3);
    upd_cnt = 0;
    for (int k = 0; k < 3; k++) dr_scan(4);
    chk(upd_cnt == 3, "R4", "pattern steps per scan", upd_cnt, 3);
    load_ir(4'h9);
    chk(integ_sel == 1'b1 && sense_en == 1'b0, "R5", "observe lines",
        {integ_sel, sense_en}, 2);
    dr_scan(5);
    load_ir(4'h0);
    chk(ext_drive == 1'b1, "R6", "extest drive", ext_drive, 1);
    dr_scan(3);
    load_ir(4'h5);
    chk({integ_sel, sense_en, ext_drive} == 3'b000, "R7", "unused code quiet",
        {integ_sel, sense_en, ext_drive}, 0);
    dr_scan(5);

    // TMS reset while generate active
    load_ir(4'h8);
    for (int k = 0; k < 5; k++) step(1, 0);
    step(1, 0);
    chk(cur_instr == 4'hF && !integ_sel && !sense_en, "R8", "TLR clears generate",
        {cur_instr, integ_sel, sense_en}, 8'hF0 >> 2);
    step(0, 0);

    // rst and Update-IR on the same edge
    shift_ir_to_update(4'h8);
    chk(tap_state == 4'hD, "R1", "stopped in Update-IR", tap_state, 4'hD);
    rst = 1'b1;
    step(0, 0);
    rst = 1'b0;
    chk(cur_instr == 4'hF, "R8", "rst beats update", cur_instr, 4'hF);
    chk(tap_state == 4'hF && !integ_sel && !sense_en, "R8", "rst state/lines",
        {tap_state, integ_sel, sense_en}, 8'h3C);
    step(0, 0);

    // random opcodes with scans
    for (int k = 0; k < 30; k++) begin
      logic [3:0] c;
      c = 4'($urandom);
      load_ir(c);
      chk({integ_sel, sense_en, ext_drive} == exp_ctl(c) >> 1, "R6", "random decode",
          {integ_sel, sense_en, ext_drive}, exp_ctl(c) >> 1);
      dr_scan(2 + int'($urandom % 7));
    end

    // random TMS walk against graph model
    model_st = tap_state;
    for (int k = 0; k < 300; k++) begin
      logic m;
      m = 1'($urandom);
      model_st = exp_next(model_st, m);
      step(m, 1'($urandom));
      chk(tap_state == model_st, "R1", "TMS walk state", tap_state, model_st);
      chk(!(bsr_update && tap_state != 4'h5), "R10", "update only in Update-DR",
          bsr_update, 0);
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule